// File: doc/BRIEF.md
# SPI Master Receive Queue with Fill-Level Ready Flag

This block is the receive half of an SPI master. It watches the serial clock and the serial input line. It assembles each incoming frame most significant bit first and places finished bytes into a four-slot queue. Data is captured on rising serial clock edges. This means the block serves both the idle-low, rising-sample timing (mode 0) and the idle-high, rising-sample timing (mode 3). In mode 3 the leading falling edge is passed over. Because every byte that arrives is clocked in by the master, the host must transmit filler bytes to pull data out of a slave.

A ready flag tells the host that the queue holds enough data to read. A threshold select chooses when the flag rises. In quarter mode it rises once one byte is held. In half mode, the default after reset, it rises only once two bytes are held. In half mode a lone byte therefore never raises the flag. The host takes data through a read strobe that is either byte wide or halfword wide. A halfword read removes two bytes at once, with the older byte in the low half.

A byte that completes while the queue is already full is thrown away and sets a sticky overrun flag.

Top module: `spi_rx_fifo`

## Requirements
- R1: After reset the queue is empty (`rxLevel` = 0), `rxReady` = 0, `overrun` = 0, and the threshold is half mode.
- R2: While `spiActive` = 1, each rising `sck` edge shifts in one `miso` bit, most significant bit first. Every eighth rising edge completes a byte. Taking `spiActive` low discards a partly received byte and restarts bit counting.
- R3: With `sck` idle high (mode 3), the falling edge that opens a frame captures no bit. The byte is built only from the eight rising edges that follow.
- R4: With `thrSel` = 0 (half mode), `rxReady` = 1 exactly when `rxLevel` >= 2.
- R5: With `thrSel` = 1 (quarter mode), `rxReady` = 1 exactly when `rxLevel` >= 1.
- R6: A change of `thrSel` alters `rxReady` from the next clock edge onward. It leaves the queued bytes and the level unchanged.
- R7: A byte read (`rdEn` = 1, `rdWide` = 0) presents the oldest byte on `rdData[7:0]` with `rdData[15:8]` = 0. It removes one byte at the clock edge.
- R8: A halfword read (`rdEn` = 1, `rdWide` = 1) with at least two bytes queued presents the oldest byte on `rdData[7:0]` and the next byte on `rdData[15:8]`. It removes both. With one byte queued it presents that byte in the low half, reads 0 in the high half, and removes one.
- R9: A read of an empty queue returns `rdData` = 0 and leaves the level unchanged.
- R10: A byte completing while `rxLevel` = 4 is discarded, and the queued bytes stay intact. `overrun` then becomes 1 and stays 1 until reset.
- R11: `rxLevel` gives the number of queued bytes, from 0 to 4. Bytes are read out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, synchronous to `clk` |
| miso | input | 1 | Serial data in |
| spiActive | input | 1 | Frame in progress; low clears the bit counter |
| thrSel | input | 1 | 1 = ready at one byte, 0 = ready at two bytes |
| rdEn | input | 1 | Read strobe; pops at the clock edge |
| rdWide | input | 1 | 1 = halfword read, 0 = byte read |
| rdData | output | 16 | Read data for the current read width |
| rxReady | output | 1 | Queue has reached the selected threshold |
| rxLevel | output | 3 | Number of queued bytes |
| overrun | output | 1 | Sticky flag: a byte was dropped on a full queue |

## Verification
The bound checker tests the following on every cycle:
- the level never exceeds four;
- the ready flag never shows on an empty queue and always shows at two or more bytes;
- a ready flag at exactly one byte only follows a quarter-mode select on the previous clock;
- the overrun flag never falls and only rises from a full queue;
- an empty read yields zero.

Only the bench scenarios can show the following:
- bit order and byte assembly;
- the mode 3 leading edge being skipped;
- partial frames being discarded;
- the packing order of halfword reads;
- arrival order preserved through the pointer wrap;
- the intact contents after a dropped byte.

// File: rtl/spi_rx_fifo_pkg.sv
package spi_rx_fifo_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic shiftEn;  // capture one serial bit
    logic pushEn;   // write the completed frame into the queue
  } rxStrobe_t;
endpackage

// File: rtl/spi_rx_fifo_ctrl.sv
module spi_rx_fifo_ctrl
  import spi_rx_fifo_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int FRAME_BITS = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             spiActive,
  input  logic             thrSel,
  input  logic             rdEn,
  input  logic             rdWide,
  output rxStrobe_t        strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [LVL_W-1:0] level,
  output logic             rxReady,
  output logic             overrun
);
  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             thrQuarter;
  logic             sckRise;
  logic             lastBit;
  logic             full;
  logic [1:0]       popCnt;

  function automatic logic [PTR_W-1:0] ptrStep(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    return PTR_W'(s % DEPTH);
  endfunction

  always_comb begin
    sckRise = spiActive & sck & ~sckPrev;
    lastBit = sckRise && (bitCnt == CNT_W'(FRAME_BITS - 1));
    full    = (level == LVL_W'(DEPTH));
    strobe.shiftEn = sckRise;
    strobe.pushEn  = lastBit && !full;
    if (!rdEn || level == '0)          popCnt = 2'd0;
    else if (rdWide && level >= LVL_W'(2)) popCnt = 2'd2;
    else                               popCnt = 2'd1;
    rxReady = thrQuarter ? (level >= LVL_W'(1)) : (level >= LVL_W'(2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sckPrev    <= 1'b0;
      bitCnt     <= '0;
      level      <= '0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      overrun    <= 1'b0;
      thrQuarter <= 1'b0;
    end else begin
      sckPrev    <= sck;
      thrQuarter <= thrSel;
      if (!spiActive)   bitCnt <= '0;
      else if (sckRise) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (strobe.pushEn) wrPtr <= ptrStep(wrPtr, 1);
      rdPtr   <= ptrStep(rdPtr, int'(popCnt));
      level   <= level + LVL_W'(strobe.pushEn) - LVL_W'(popCnt);
      overrun <= overrun | (lastBit & full);
    end
  end
endmodule

// File: rtl/spi_rx_fifo_dpath.sv
module spi_rx_fifo_dpath
  import spi_rx_fifo_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int FRAME_BITS = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miso,
  input  logic                    rdWide,
  input  rxStrobe_t               strobe,
  input  logic [PTR_W-1:0]        wrPtr,
  input  logic [PTR_W-1:0]        rdPtr,
  input  logic [LVL_W-1:0]        level,
  output logic [2*FRAME_BITS-1:0] rdData
);
  logic [FRAME_BITS-2:0] shiftReg;
  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-1:0] slots [DEPTH];
  logic [PTR_W-1:0]      rdNext;

  always_comb begin
    frame  = {shiftReg, miso};
    rdNext = (int'(rdPtr) == DEPTH - 1) ? '0 : rdPtr + 1'b1;
    rdData[FRAME_BITS-1:0] = (level >= LVL_W'(1)) ? slots[rdPtr] : '0;
    rdData[2*FRAME_BITS-1:FRAME_BITS] =
      (rdWide && level >= LVL_W'(2)) ? slots[rdNext] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= frame[FRAME_BITS-2:0];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rst_n) slots[g] <= '0;
      else if (strobe.pushEn && int'(wrPtr) == g) slots[g] <= frame;
    end
  end
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo
  import spi_rx_fifo_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int FRAME_BITS = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    miso,
  input  logic                    spiActive,
  input  logic                    thrSel,
  input  logic                    rdEn,
  input  logic                    rdWide,
  output logic [2*FRAME_BITS-1:0] rdData,
  output logic                    rxReady,
  output logic [LVL_W-1:0]        rxLevel,
  output logic                    overrun
);
  rxStrobe_t        strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  spi_rx_fifo_ctrl #(.DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck(sck), .spiActive(spiActive),
    .thrSel(thrSel), .rdEn(rdEn), .rdWide(rdWide), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .level(rxLevel), .rxReady(rxReady),
    .overrun(overrun)
  );

  spi_rx_fifo_dpath #(.DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS)) u_dpath (
    .clk(clk), .rst_n(rst_n), .miso(miso), .rdWide(rdWide), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .level(rxLevel), .rdData(rdData)
  );
endmodule

// File: rtl/spi_rx_fifo_chk.sv
module spi_rx_fifo_chk #(
  parameter int DEPTH      = 4,
  parameter int FRAME_BITS = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    thrSel,
  input logic                    rdEn,
  input logic [2*FRAME_BITS-1:0] rdData,
  input logic                    rxReady,
  input logic [LVL_W-1:0]        rxLevel,
  input logic                    overrun
);
  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rxLevel) <= DEPTH);
  // R4
  half_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLevel >= LVL_W'(2)) |-> rxReady);
  // R5
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLevel == '0) |-> !rxReady);
  // R6
  quarter_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLevel == LVL_W'(1) && rxReady) |-> $past(thrSel));
  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R10
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (int'($past(rxLevel)) == DEPTH));
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rxLevel == '0) |-> (rdData == '0));
endmodule

bind spi_rx_fifo spi_rx_fifo_chk #(.DEPTH(DEPTH), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .thrSel(thrSel), .rdEn(rdEn), .rdData(rdData),
  .rxReady(rxReady), .rxLevel(rxLevel), .overrun(overrun)
);

// File: tb/spi_rx_fifo_tb.sv
module spi_rx_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, sck = 0, miso = 0, spiActive = 0;
  logic thrSel = 0, rdEn = 0, rdWide = 0;
  logic [15:0] rdData;
  logic rxReady, overrun;
  logic [2:0] rxLevel;

  int checks = 0, failures = 0;
  bit done = 0;
  byte unsigned q[$];
  bit ovrExp = 0, thrExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_fifo u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit readyExp();
    return thrExp ? (q.size() >= 1) : (q.size() >= 2);
  endfunction

  task automatic checkState(input string tag);
    check({tag, " R11 level"}, int'(rxLevel), q.size());
    check({tag, " R4/R5 ready"}, int'(rxReady), int'(readyExp()));
    check({tag, " R10 overrun"}, int'(overrun), int'(ovrExp));
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; spiActive = 0; sck = 0; rdEn = 0; thrSel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    q.delete(); ovrExp = 0; thrExp = 0;
  endtask

  // drive bits MSB first; each rising sck edge is seen at the next posedge
  task automatic sendBits(input byte unsigned b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); sck = 0; miso = b[i];
      @(negedge clk); sck = 1;
      @(negedge clk);
    end
  endtask

  task automatic sendByte(input byte unsigned b);
    spiActive = 1;
    sendBits(b, 8);
    if (q.size() < 4) q.push_back(b); else ovrExp = 1;
  endtask

  task automatic doRead(input bit wide, input string tag);
    int lo, hi, n;
    @(negedge clk);
    rdEn = 1; rdWide = wide;
    #1;
    lo = (q.size() >= 1) ? q[0] : 0;
    hi = (wide && q.size() >= 2) ? q[1] : 0;
    check({tag, wide ? " R8 wide data" : " R7 byte data"}, int'(rdData), (hi << 8) | lo);
    @(negedge clk);
    rdEn = 0;
    n = (q.size() == 0) ? 0 : ((wide && q.size() >= 2) ? 2 : 1);
    for (int k = 0; k < n; k++) void'(q.pop_front());
    checkState(tag);
  endtask

  task automatic setThr(input bit v);
    @(negedge clk); thrSel = v;
    #1;
    check("R6 ready before edge", int'(rxReady), int'(readyExp()));
    @(negedge clk); thrExp = v;
    checkState("R6 after edge");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    doReset();
    @(negedge clk);
    checkState("R1 reset");
    doRead(1'b0, "R9 empty byte read");
    doRead(1'b1, "R9 empty wide read");

    // R2 R4: one byte in half mode does not raise ready
    sendByte(8'hA5);
    checkState("R4 one byte half");
    setThr(1'b1);   // R5 R6
    setThr(1'b0);
    sendByte(8'h3C);
    checkState("R4 two bytes half");
    doRead(1'b1, "R8 wide pop two");

    // R8 wide read with only one byte
    sendByte(8'h81);
    doRead(1'b1, "R8 wide one byte");

    // R2 aborted partial frame
    spiActive = 1;
    sendBits(8'hFF, 3);
    @(negedge clk); spiActive = 0;
    @(negedge clk);
    sendByte(8'h12);
    checkState("R2 after abort");
    doRead(1'b0, "R2 abort data");

    // R3 mode 3: idle high, leading falling edge skipped
    @(negedge clk); spiActive = 0; sck = 1;
    repeat (2) @(negedge clk);
    spiActive = 1;
    @(negedge clk);
    sendByte(8'h96);
    sendByte(8'h4B);
    checkState("R3 mode3 level");
    doRead(1'b1, "R3 mode3 data");
    @(negedge clk); sck = 0; spiActive = 0;

    // R10 overfill
    for (int i = 0; i < 5; i++) sendByte(byte'(8'h10 + i));
    checkState("R10 full drop");
    doRead(1'b0, "R10 contents kept");
    doRead(1'b1, "R10 contents kept");
    checkState("R10 sticky");
    doReset();
    @(negedge clk);
    checkState("R1 overrun cleared");

    // constrained random mix, R11 ordering through wrap
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 5) sendByte(byte'($urandom_range(0, 255)));
      else if (op < 9) doRead(bit'($urandom_range(0, 1)), "R11 random read");
      else setThr(bit'($urandom_range(0, 1)));
      checkState("R11 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule